// File: doc/BRIEF.md
# Byte-Stream Transmit Framer for a Contactless Reader

This block turns bytes held in a FIFO into a serial bit stream for a contactless reader's transmitter. A bit-strobe input sets the pace: each strobe during a frame releases one symbol on the serial output, together with a one-cycle valid flag. A start pulse opens a frame. The frame may begin with a start-of-frame symbol and close with an end-of-frame symbol. Every byte goes out least significant bit first and may be followed by an odd parity bit.

The frame has no fixed length. Once per byte, at a fixed check point, the framer tests whether the FIFO holds another byte. If it does, it takes that byte and the frame grows by one byte. If it does not, the current byte is the last one, and the frame closes. Bytes written after that moment stay in the FIFO for the next frame. A non-zero last-bits setting cuts the final byte short. The check point then moves forward to the truncated length, so that the framer learns early enough that the byte may be cut. With parity on and a full final byte, the check point moves one bit later, onto the parity bit.

The configuration inputs are captured when a start is accepted and stay fixed for the rest of that frame. The FIFO is read in first-word-fall-through style: `fifo_data` shows the head byte whenever `fifo_empty` is low, and the byte leaves on a `fifo_rd` pulse.

Top module: `rf_tx_framer`

## Requirements
- R1: A start pulse while idle and with `fifo_empty` low opens a frame. `busy` is high in the next cycle, and `fifo_rd` pulses in that same cycle to remove the first byte.
- R2: A start pulse has no effect while `fifo_empty` is high or while a frame is in progress. No symbol is produced, and the frame in progress continues unchanged.
- R3: During a frame, each `bit_tick` pulse produces exactly one symbol, with `tx_valid` high in the cycle after the pulse. Data bits leave least significant bit first. Outside a frame, no symbol is produced.
- R4: When the start-of-frame enable is captured high, the first symbol of the frame is a marker with `tx_mark`=1 and `tx_bit`=0, ahead of the first data bit.
- R5: When parity is enabled, each full byte is followed by one parity bit chosen so that the 8 data bits plus the parity bit contain an odd number of ones.
- R6: The FIFO check point is fixed by the configuration. With last-bits 0 and parity off, it is data bit 7. With last-bits 0 and parity on, it is the parity bit. With last-bits k (1 to 7), it is data bit k-1. If the FIFO is not empty at that tick, its head byte is taken and becomes the next byte of the frame.
- R7: If the FIFO is empty at the check point, the current byte is the final one. A byte written to the FIFO after that tick is not read (no `fifo_rd`) and is not sent in this frame.
- R8: With last-bits k non-zero, the final byte sends only its bits 0 to k-1 and carries no parity bit. Earlier bytes of the frame are sent in full. Last-bits 0 sends the whole final byte.
- R9: When the end-of-frame enable is captured high, the last symbol of the frame is a marker with `tx_mark`=1 and `tx_bit`=1, following the final data or parity bit.
- R10: `done` is high for exactly one cycle, in the same cycle as the frame's final symbol. `busy` falls in that cycle and is high in every cycle of the frame before it.
- R11: `fifo_rd` pulses only when the FIFO was not empty in the previous cycle, and exactly once for each byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that opens a frame |
| bit_tick | input | 1 | Bit-rate strobe; one symbol per pulse during a frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | DATA_W | Head byte of the FIFO (first-word-fall-through) |
| fifo_rd | output | 1 | Removes the head byte from the FIFO |
| cfg_parity_en | input | 1 | Append an odd parity bit to each full byte |
| cfg_last_bits | input | IDX_W | Bits sent of the final byte; 0 means the whole byte |
| cfg_sof_en | input | 1 | Send a start-of-frame marker |
| cfg_eof_en | input | 1 | Send an end-of-frame marker |
| tx_bit | output | 1 | Serial symbol value |
| tx_valid | output | 1 | One-cycle flag marking a new symbol |
| tx_mark | output | 1 | The current symbol is a frame marker, not data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse with the frame's final symbol |

## Verification
Every output is registered, and each result is due at a fixed cycle. `busy` and the first `fifo_rd` appear one cycle after an accepted start. Each symbol appears one cycle after its `bit_tick`. Later `fifo_rd` pulses come one cycle after the check-point tick, and `done` arrives together with the last symbol. The bench drives inputs and samples outputs at falling edges, so the symbol belonging to each strobe is read at the first falling edge after it. A scoreboard holds the expected symbols, built from the bytes and settings, and compares them in order. Each expected symbol carries a flag that says whether `done` must come with it. After a frame, the bench counts the `fifo_rd` pulses and `done` pulses, which exposes early or late closing of the frame.

// File: rtl/rf_txf_pkg.sv
package rf_txf_pkg;

  typedef enum logic [2:0] {
    TXF_IDLE,
    TXF_SOF,
    TXF_DATA,
    TXF_PAR,
    TXF_EOF
  } txf_state_e;

endpackage

// File: rtl/rf_txf_checkpoint.sv
// Decides whether the current symbol position is where the FIFO is polled.
module rf_txf_checkpoint #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic             par_en,
  input  logic [IDX_W-1:0] last_bits,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             in_par,
  output logic             at_check,
  output logic             byte_end
);

  logic trunc;

  always_comb begin
    trunc    = (last_bits != '0);
    byte_end = (bit_idx == IDX_W'(DATA_W - 1));
    if (in_par)
      at_check = par_en && !trunc;
    else if (trunc)
      at_check = (bit_idx == last_bits - IDX_W'(1));
    else
      at_check = !par_en && byte_end;
  end

endmodule

// File: rtl/rf_txf_datapath.sv
// Holds the byte being shifted out and the byte already taken for later.
module rf_txf_datapath #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              ld_cur_fifo,
  input  logic              ld_cur_hold,
  input  logic              ld_hold_fifo,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              cur_bit,
  output logic              par_bit
);

  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      hold_q <= '0;
    end else begin
      if (ld_cur_fifo)
        cur_q <= fifo_data;
      else if (ld_cur_hold)
        cur_q <= hold_q;
      if (ld_hold_fifo)
        hold_q <= fifo_data;
    end
  end

  assign cur_bit = cur_q[bit_idx];
  assign par_bit = ~(^cur_q);

endmodule

// File: rtl/rf_txf_ctrl.sv
// Frame sequencer: start acceptance, symbol emission, FIFO polling and close.
module rf_txf_ctrl
  import rf_txf_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_tick,
  input  logic             fifo_empty,
  input  logic             cfg_parity_en,
  input  logic [IDX_W-1:0] cfg_last_bits,
  input  logic             cfg_sof_en,
  input  logic             cfg_eof_en,
  input  logic             cur_bit,
  input  logic             par_bit,
  input  logic             at_check,
  input  logic             byte_end,
  output logic             in_par,
  output logic             par_q,
  output logic [IDX_W-1:0] lb_q,
  output logic [IDX_W-1:0] bit_idx,
  output logic             ld_cur_fifo,
  output logic             ld_cur_hold,
  output logic             ld_hold_fifo,
  output logic             fifo_rd,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             tx_mark,
  output logic             busy,
  output logic             done
);

  txf_state_e state;
  logic       sof_q, eof_q;
  logic       accept, close, enter_par, pop;

  assign in_par = (state == TXF_PAR);

  always_comb begin
    accept       = 1'b0;
    close        = 1'b0;
    enter_par    = 1'b0;
    pop          = 1'b0;
    ld_cur_fifo  = 1'b0;
    ld_cur_hold  = 1'b0;
    ld_hold_fifo = 1'b0;
    case (state)
      TXF_IDLE: if (start && !fifo_empty) begin
        accept      = 1'b1;
        ld_cur_fifo = 1'b1;
        pop         = 1'b1;
      end
      TXF_DATA: if (bit_tick) begin
        if (at_check && fifo_empty)
          close = 1'b1;
        else if (at_check && byte_end) begin
          ld_cur_fifo = 1'b1;
          pop         = 1'b1;
        end else if (at_check) begin
          ld_hold_fifo = 1'b1;
          pop          = 1'b1;
        end else if (byte_end && par_q)
          enter_par = 1'b1;
        else if (byte_end)
          ld_cur_hold = 1'b1;
      end
      TXF_PAR: if (bit_tick) begin
        if (at_check && fifo_empty)
          close = 1'b1;
        else if (at_check) begin
          ld_cur_fifo = 1'b1;
          pop         = 1'b1;
        end else
          ld_cur_hold = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TXF_IDLE;
      bit_idx  <= '0;
      par_q    <= 1'b0;
      lb_q     <= '0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      fifo_rd  <= 1'b0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_mark  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      fifo_rd  <= pop;
      tx_valid <= 1'b0;
      tx_mark  <= 1'b0;
      done     <= 1'b0;
      case (state)
        TXF_IDLE: if (accept) begin
          busy    <= 1'b1;
          bit_idx <= '0;
          par_q   <= cfg_parity_en;
          lb_q    <= cfg_last_bits;
          sof_q   <= cfg_sof_en;
          eof_q   <= cfg_eof_en;
          state   <= cfg_sof_en ? TXF_SOF : TXF_DATA;
        end
        TXF_SOF: if (bit_tick) begin
          tx_valid <= 1'b1;
          tx_mark  <= 1'b1;
          tx_bit   <= 1'b0;
          state    <= TXF_DATA;
        end
        TXF_DATA: if (bit_tick) begin
          tx_valid <= 1'b1;
          tx_bit   <= cur_bit;
          if (close) begin
            if (eof_q)
              state <= TXF_EOF;
            else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= TXF_IDLE;
            end
          end else if (enter_par)
            state <= TXF_PAR;
          else
            bit_idx <= byte_end ? '0 : bit_idx + IDX_W'(1);
        end
        TXF_PAR: if (bit_tick) begin
          tx_valid <= 1'b1;
          tx_bit   <= par_bit;
          if (close) begin
            if (eof_q)
              state <= TXF_EOF;
            else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= TXF_IDLE;
            end
          end else begin
            bit_idx <= '0;
            state   <= TXF_DATA;
          end
        end
        TXF_EOF: if (bit_tick) begin
          tx_valid <= 1'b1;
          tx_mark  <= 1'b1;
          tx_bit   <= 1'b1;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= TXF_IDLE;
        end
        default: state <= TXF_IDLE;
      endcase
      if (state == TXF_IDLE && !accept)
        sof_q <= sof_q;
    end
  end

endmodule

// File: rtl/rf_tx_framer.sv
module rf_tx_framer #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bit_tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  input  logic              cfg_parity_en,
  input  logic [IDX_W-1:0]  cfg_last_bits,
  input  logic              cfg_sof_en,
  input  logic              cfg_eof_en,
  output logic              tx_bit,
  output logic              tx_valid,
  output logic              tx_mark,
  output logic              busy,
  output logic              done
);

  logic             cur_bit, par_bit, at_check, byte_end, in_par, par_q;
  logic [IDX_W-1:0] lb_q, bit_idx;
  logic             ld_cur_fifo, ld_cur_hold, ld_hold_fifo;

  rf_txf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .bit_tick     (bit_tick),
    .fifo_empty   (fifo_empty),
    .cfg_parity_en(cfg_parity_en),
    .cfg_last_bits(cfg_last_bits),
    .cfg_sof_en   (cfg_sof_en),
    .cfg_eof_en   (cfg_eof_en),
    .cur_bit      (cur_bit),
    .par_bit      (par_bit),
    .at_check     (at_check),
    .byte_end     (byte_end),
    .in_par       (in_par),
    .par_q        (par_q),
    .lb_q         (lb_q),
    .bit_idx      (bit_idx),
    .ld_cur_fifo  (ld_cur_fifo),
    .ld_cur_hold  (ld_cur_hold),
    .ld_hold_fifo (ld_hold_fifo),
    .fifo_rd      (fifo_rd),
    .tx_bit       (tx_bit),
    .tx_valid     (tx_valid),
    .tx_mark      (tx_mark),
    .busy         (busy),
    .done         (done)
  );

  rf_txf_checkpoint #(.DATA_W(DATA_W)) u_chkpt (
    .par_en   (par_q),
    .last_bits(lb_q),
    .bit_idx  (bit_idx),
    .in_par   (in_par),
    .at_check (at_check),
    .byte_end (byte_end)
  );

  rf_txf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .fifo_data   (fifo_data),
    .ld_cur_fifo (ld_cur_fifo),
    .ld_cur_hold (ld_cur_hold),
    .ld_hold_fifo(ld_hold_fifo),
    .bit_idx     (bit_idx),
    .cur_bit     (cur_bit),
    .par_bit     (par_bit)
  );

endmodule

// File: rtl/rf_tx_framer_chk.sv
module rf_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic bit_tick,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic tx_valid,
  input logic tx_mark,
  input logic busy,
  input logic done
);

  // R1: accepted start raises busy and pops the first byte
  p_start_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !fifo_empty) |=> (busy && fifo_rd));

  // R2: start with an empty FIFO leaves the block idle
  p_start_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && fifo_empty) |=> !busy);

  // R3: a symbol only follows a strobe
  p_valid_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bit_tick));

  // R3: no symbol outside a frame
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> !tx_valid);

  // R4 / R9: a marker is always a valid symbol
  p_mark_valid_r4: assert property (@(posedge clk) disable iff (rst)
    tx_mark |-> tx_valid);

  // R10: done is a single-cycle pulse that comes with the final symbol
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_symbol_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (tx_valid && !busy));

  // R10: busy only drops when done is given
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11: reads only from a non-empty FIFO
  p_rd_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> $past(!fifo_empty));

endmodule

bind rf_tx_framer rf_tx_framer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .bit_tick  (bit_tick),
  .fifo_empty(fifo_empty),
  .fifo_rd   (fifo_rd),
  .tx_valid  (tx_valid),
  .tx_mark   (tx_mark),
  .busy      (busy),
  .done      (done)
);

// File: tb/rf_tx_framer_test.sv
`timescale 1ns/1ps
module rf_tx_framer_test;

  typedef struct packed {
    logic       mark;
    logic       bitv;
    logic       last;
    logic [3:0] req;
  } sym_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       bit_tick = 1'b0;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_rd;
  logic       cfg_parity_en = 1'b0;
  logic [2:0] cfg_last_bits = 3'd0;
  logic       cfg_sof_en = 1'b0;
  logic       cfg_eof_en = 1'b0;
  logic       tx_bit, tx_valid, tx_mark, busy, done;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] fmem [0:63];
  int wr_ptr = 0;
  int rd_ptr;
  sym_t exp_q[$];
  logic [7:0] pre_q[$];
  logic [7:0] sent_q[$];

  always #2.5 clk = ~clk;

  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = fmem[rd_ptr[5:0]];

  always @(posedge clk) begin
    if (rst) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end

  rf_tx_framer uut (
    .clk(clk), .rst(rst), .start(start), .bit_tick(bit_tick),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .cfg_parity_en(cfg_parity_en), .cfg_last_bits(cfg_last_bits),
    .cfg_sof_en(cfg_sof_en), .cfg_eof_en(cfg_eof_en),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_mark(tx_mark),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every symbol
  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_rd) rd_cnt++;
      if (done) done_cnt++;
      if (done && !tx_valid)
        check(1'b0, "R10 done without symbol", 1, 0);
      if (tx_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R3 unexpected symbol", 1, 0);
        else begin
          sym_t e;
          e = exp_q.pop_front();
          check(tx_bit == e.bitv && tx_mark == e.mark,
                $sformatf("R%0d symbol {mark,bit}", e.req),
                {30'd0, tx_mark, tx_bit}, {30'd0, e.mark, e.bitv});
          check(done == e.last, "R10 done alignment", int'(done), int'(e.last));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_up();
    end
  end

  task automatic push(input logic [7:0] b);
    fmem[wr_ptr[5:0]] = b;
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic add_sym(input logic mark, input logic bv, input int req);
    sym_t s;
    s.mark = mark; s.bitv = bv; s.last = 1'b0; s.req = 4'(req);
    exp_q.push_back(s);
  endtask

  // Driver: expected symbols from the requirements (R3, R4, R5, R8, R9)
  task automatic build_expected(input bit par, input int lb, input bit sof, input bit eof);
    sym_t s;
    if (sof) add_sym(1'b1, 1'b0, 4);
    foreach (sent_q[i]) begin
      bit fin;
      int nb;
      fin = (i == sent_q.size() - 1);
      nb  = (fin && lb != 0) ? lb : 8;
      for (int b = 0; b < nb; b++)
        add_sym(1'b0, sent_q[i][b], (fin && lb != 0) ? 8 : 3);
      if (par && !(fin && lb != 0))
        add_sym(1'b0, ~(^sent_q[i]), 5);
    end
    if (eof) add_sym(1'b1, 1'b1, 9);
    s = exp_q.pop_back();
    s.last = 1'b1;
    exp_q.push_back(s);
  endtask

  task automatic run_frame(input bit par, input int lb, input bit sof, input bit eof,
                           input int push_at, input logic [7:0] push_val);
    int nsym, rd_base, done_base;
    cfg_parity_en = par; cfg_last_bits = 3'(lb); cfg_sof_en = sof; cfg_eof_en = eof;
    foreach (pre_q[i]) push(pre_q[i]);
    build_expected(par, lb, sof, eof);
    nsym = exp_q.size();
    rd_base = rd_cnt; done_base = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    check(fifo_rd == 1'b1, "R1 first read", int'(fifo_rd), 1);
    // scramble config after capture: must not matter
    cfg_parity_en = ~par; cfg_last_bits = 3'(lb + 3); cfg_sof_en = ~sof; cfg_eof_en = ~eof;
    for (int k = 0; k < nsym; k++) begin
      if (k == push_at) push(push_val);
      bit_tick = 1'b1;
      start = (k == 2);             // R2: start during a frame is ignored
      @(negedge clk);
      bit_tick = 1'b0; start = 1'b0;
      if (k < nsym - 1)
        check(busy == 1'b1, "R10 busy inside frame", int'(busy), 1);
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R10 busy after frame", int'(busy), 0);
    check(exp_q.size() == 0, "R3 symbols left over", exp_q.size(), 0);
    check(done_cnt - done_base == 1, "R10 done count", done_cnt - done_base, 1);
    check(rd_cnt - rd_base == sent_q.size(), "R11 read count", rd_cnt - rd_base, sent_q.size());
    exp_q.delete();
    pre_q.delete();
    sent_q.delete();
  endtask

  initial begin
    rd_ptr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10 reset state", int'(busy), 0);
    check(tx_valid == 1'b0 && fifo_rd == 1'b0, "R3 reset outputs", int'(tx_valid), 0);

    // R2: start with empty FIFO, and strobes while idle produce nothing
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
    end
    check(busy == 1'b0, "R2 start on empty FIFO", int'(busy), 0);
    check(rd_cnt == 0, "R2 no read on empty FIFO", rd_cnt, 0);

    // R3 R6: two full bytes, no parity, no markers
    pre_q = '{8'hA5, 8'h3C}; sent_q = '{8'hA5, 8'h3C};
    run_frame(1'b0, 0, 1'b0, 1'b0, -1, 8'h00);

    // R4 R5 R9: three bytes with parity and both markers
    pre_q = '{8'h01, 8'h80, 8'hFF}; sent_q = '{8'h01, 8'h80, 8'hFF};
    run_frame(1'b1, 0, 1'b1, 1'b1, -1, 8'h00);

    // R6 R8: last-bits 4, first byte kept full with parity, final cut to 4 bits
    pre_q = '{8'h5A, 8'h0F}; sent_q = '{8'h5A, 8'h0F};
    run_frame(1'b1, 4, 1'b0, 1'b1, -1, 8'h00);

    // R8: single byte cut to one bit, with start marker
    pre_q = '{8'h96}; sent_q = '{8'h96};
    run_frame(1'b0, 1, 1'b1, 1'b0, -1, 8'h00);

    // R6: byte written before the parity check point is appended
    pre_q = '{8'h11}; sent_q = '{8'h11, 8'h22};
    run_frame(1'b1, 0, 1'b0, 1'b0, 2, 8'h22);

    // R7: byte written after the check point (before end marker) is not taken
    pre_q = '{8'h77}; sent_q = '{8'h77};
    run_frame(1'b0, 0, 1'b0, 1'b1, 8, 8'hEE);
    check(fifo_empty == 1'b0, "R7 late byte kept", int'(fifo_empty), 0);

    // R7: the kept byte is the whole next frame, last-bits 7
    sent_q = '{8'hEE};
    run_frame(1'b1, 7, 1'b1, 1'b1, -1, 8'h00);

    finish_up();
  end

endmodule